// File: doc/BRIEF.md
# Collective Reduce-on-Transfer Element Combiner

This block sits in the data path of a DMA engine that carries collective traffic between ranks. For every pair of 32-bit words it receives, `a` being the incoming word and `b` the word already at the destination, it returns either `a` unchanged (a copy) or `b op a` (a reduction). Three static configuration codes decide which: the collective kind, a wide ALU opcode and an element data-type code. Only reducing kinds of collective combine the data; every other kind is a plain copy, and for those the opcode does not matter.

The ALU opcode space is first narrowed to a small compute code: none, add, multiply, max or min. The block also produces a second, shorter code on a side output, for a neighbouring transfer unit that uses a different numbering. The data type sets the lane packing inside each word (four 8-bit lanes, two 16-bit lanes or one 32-bit lane) and the signedness of comparisons. Lanes never interact, and add wraps within each lane.

A configuration that cannot be carried out raises an error output. While the error is raised, the block accepts no input. The stream passes through one register stage with standard valid/ready flow control.

Top module: `coll_reduce_dp`

## Requirements
- R1: A collective kind code of 0, or any code above 9, sets `cfg_err` to 1 and holds `in_ready` low.
- R2: Kind codes 3, 4, 5, 7 and 9 are copy kinds. They give `cfg_cop` = 0 (none), `cfg_err` = 0 and `out_data` equal to `in_a`, whatever the opcode and data-type codes are.
- R3: For reducing kinds 1, 2, 6 and 8 with a legal data type, opcodes 0x04 and 0xC4 give `cfg_cop` = 1 (add), opcodes 0x08, 0xCF and 0xD5 give 3 (max), and opcodes 0x09, 0xD0 and 0xD6 give 4 (min).
- R4: `cfg_cce` is 0 when the compute code is add, 2 when it is max and 3 when it is min. It is 0 when the compute code is none.
- R5: Data-type codes 0x2 (signed) and 0x3 (unsigned) pack four 8-bit lanes, lane i at bits [8i+7:8i]. Codes 0x4 (signed) and 0x5 (unsigned) pack two 16-bit lanes. Codes 0x8 (signed) and 0x9 (unsigned) pack one 32-bit lane. Each lane of `out_data` is computed from the same lane of `in_b` and `in_a` only.
- R6: Add returns (b + a) modulo 2^lane-width in each lane, with no carry into the next lane.
- R7: Opcodes 0xCF and 0xD0 compare lanes as signed and 0xD5 and 0xD6 compare them as unsigned, whatever the data type. Opcodes 0x08 and 0x09 take their signedness from the data-type code.
- R8: On a reducing kind, an opcode or data-type code outside the lists in R3 and R5 sets `cfg_err`. `in_ready` then stays low and no new output word appears until the configuration changes.
- R9: A word accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values. With `out_ready` held high, one word is accepted every cycle, and no word is dropped or duplicated.
- R10: After reset, `out_valid` is 0 and, with a legal configuration, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctype | input | 8 | Collective kind code |
| cfg_aluop | input | 8 | ALU opcode |
| cfg_dtype | input | 8 | Element data-type code |
| cfg_err | output | 1 | Illegal configuration |
| cfg_cop | output | 3 | Compute code (0 none, 1 add, 2 multiply, 3 max, 4 min) |
| cfg_cce | output | 2 | Side encoding of the compute code (add 0, max 2, min 3) |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_a | input | 32 | Incoming word |
| in_b | input | 32 | Existing destination word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | 32 | Result word |

## Verification
The bench aims at the lane edges. It uses 0xFF + 0x01 in byte lanes, where a design with carries between lanes would change the neighbouring byte. It uses 0x80 against 0x7F, where a design that mixed up signedness would pick the wrong winner, and the same operands under each forced-sign opcode combined with the opposite data type. It checks that copy kinds ignore a nonsense opcode, and that bad kind, opcode and data-type codes stall the input instead of leaking words out. Long random streams, with random back-pressure, catch any word that is lost or repeated across a stall.

// File: rtl/reduce_pkg.sv
package reduce_pkg;
  typedef enum logic [2:0] {
    COP_NONE = 3'd0,
    COP_ADD  = 3'd1,
    COP_MUL  = 3'd2,
    COP_MAX  = 3'd3,
    COP_MIN  = 3'd4
  } cop_e;

  typedef enum logic [1:0] {
    LSEL_8  = 2'd0,
    LSEL_16 = 2'd1,
    LSEL_32 = 2'd2
  } lsel_e;

  localparam int CODE_W = 8;

  // side encoding used by the neighbouring transfer unit
  function automatic logic [1:0] cce_of(cop_e c);
    case (c)
      COP_MAX: cce_of = 2'd2;
      COP_MIN: cce_of = 2'd3;
      default: cce_of = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/rdx_cfg_decode.sv
module rdx_cfg_decode
  import reduce_pkg::*;
(
  input  logic [CODE_W-1:0] ctype,
  input  logic [CODE_W-1:0] aluop,
  input  logic [CODE_W-1:0] dtype,
  output cop_e              cop,
  output logic [1:0]        cce,
  output lsel_e             lsel,
  output logic              sgn,
  output logic              err
);
  logic kind_reduce, kind_copy;
  logic op_ok, dt_ok, dt_sgn, force_sgn, forced_val;
  cop_e op_cop;

  always_comb begin
    kind_reduce = 1'b0;
    kind_copy   = 1'b0;
    case (ctype)
      8'd1, 8'd2, 8'd6, 8'd8:         kind_reduce = 1'b1;
      8'd3, 8'd4, 8'd5, 8'd7, 8'd9:   kind_copy   = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    op_ok      = 1'b1;
    op_cop     = COP_NONE;
    force_sgn  = 1'b0;
    forced_val = 1'b0;
    case (aluop)
      8'h04, 8'hC4: op_cop = COP_ADD;
      8'h08:        op_cop = COP_MAX;
      8'h09:        op_cop = COP_MIN;
      8'hCF: begin op_cop = COP_MAX; force_sgn = 1'b1; forced_val = 1'b1; end
      8'hD0: begin op_cop = COP_MIN; force_sgn = 1'b1; forced_val = 1'b1; end
      8'hD5: begin op_cop = COP_MAX; force_sgn = 1'b1; end
      8'hD6: begin op_cop = COP_MIN; force_sgn = 1'b1; end
      default: op_ok = 1'b0;
    endcase
  end

  always_comb begin
    dt_ok  = 1'b1;
    dt_sgn = 1'b0;
    lsel   = LSEL_32;
    case (dtype)
      8'h2: begin lsel = LSEL_8;  dt_sgn = 1'b1; end
      8'h3:       lsel = LSEL_8;
      8'h4: begin lsel = LSEL_16; dt_sgn = 1'b1; end
      8'h5:       lsel = LSEL_16;
      8'h8:       dt_sgn = 1'b1;
      8'h9:       ;
      default: dt_ok = 1'b0;
    endcase
  end

  assign err = !(kind_reduce || kind_copy) || (kind_reduce && !(op_ok && dt_ok));
  assign cop = (kind_reduce && op_ok && dt_ok) ? op_cop : COP_NONE;
  assign sgn = force_sgn ? forced_val : dt_sgn;
  assign cce = cce_of(cop);
endmodule

// File: rtl/rdx_lane.sv
module rdx_lane
  import reduce_pkg::*;
#(
  parameter int LW = 8
) (
  input  cop_e          cop,
  input  logic          sgn,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [LW-1:0] r
);
  function automatic logic b_above(logic s, logic [LW-1:0] x, logic [LW-1:0] y);
    b_above = s ? ($signed(y) > $signed(x)) : (y > x);
  endfunction

  function automatic logic b_below(logic s, logic [LW-1:0] x, logic [LW-1:0] y);
    b_below = s ? ($signed(y) < $signed(x)) : (y < x);
  endfunction

  always_comb begin
    case (cop)
      COP_ADD: r = b + a;
      COP_MUL: r = b * a;
      COP_MAX: r = b_above(sgn, a, b) ? b : a;
      COP_MIN: r = b_below(sgn, a, b) ? b : a;
      default: r = a;
    endcase
  end
endmodule

// File: rtl/rdx_word_alu.sv
module rdx_word_alu
  import reduce_pkg::*;
#(
  parameter int DW = 32
) (
  input  cop_e          cop,
  input  lsel_e         lsel,
  input  logic          sgn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r
);
  localparam int N8  = DW / 8;
  localparam int N16 = DW / 16;
  localparam int N32 = DW / 32;

  logic [DW-1:0] r8, r16, r32;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    rdx_lane #(.LW(8)) u_lane (.cop(cop), .sgn(sgn), .a(a[g*8 +: 8]),
                               .b(b[g*8 +: 8]), .r(r8[g*8 +: 8]));
  end
  for (genvar g = 0; g < N16; g++) begin : g_l16
    rdx_lane #(.LW(16)) u_lane (.cop(cop), .sgn(sgn), .a(a[g*16 +: 16]),
                                .b(b[g*16 +: 16]), .r(r16[g*16 +: 16]));
  end
  for (genvar g = 0; g < N32; g++) begin : g_l32
    rdx_lane #(.LW(32)) u_lane (.cop(cop), .sgn(sgn), .a(a[g*32 +: 32]),
                                .b(b[g*32 +: 32]), .r(r32[g*32 +: 32]));
  end

  always_comb begin
    case (lsel)
      LSEL_8:  r = r8;
      LSEL_16: r = r16;
      default: r = r32;
    endcase
  end
endmodule

// File: rtl/rdx_out_stage.sv
module rdx_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] d,
  input  logic          out_ready,
  output logic          room,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9
  take_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/coll_reduce_dp.sv
module coll_reduce_dp
  import reduce_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_ctype,
  input  logic [7:0]  cfg_aluop,
  input  logic [7:0]  cfg_dtype,
  output logic        cfg_err,
  output logic [2:0]  cfg_cop,
  output logic [1:0]  cfg_cce,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [DW-1:0] out_data
);
  cop_e          cop;
  lsel_e         lsel;
  logic          sgn;
  logic          room;
  logic          accept;
  logic [DW-1:0] result;

  rdx_cfg_decode u_dec (
    .ctype(cfg_ctype), .aluop(cfg_aluop), .dtype(cfg_dtype),
    .cop(cop), .cce(cfg_cce), .lsel(lsel), .sgn(sgn), .err(cfg_err)
  );

  assign cfg_cop = cop;

  rdx_word_alu #(.DW(DW)) u_alu (
    .cop(cop), .lsel(lsel), .sgn(sgn), .a(in_a), .b(in_b), .r(result)
  );

  assign in_ready = room && !cfg_err;
  assign accept   = in_valid && in_ready;

  rdx_out_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .take(accept), .d(result),
    .out_ready(out_ready), .room(room), .out_valid(out_valid), .out_data(out_data)
  );

  // R1
  bad_kind_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctype == 8'd0 || cfg_ctype > 8'd9) |-> cfg_err && !in_ready);
  // R2
  copy_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctype inside {8'd3, 8'd4, 8'd5, 8'd7, 8'd9}) |-> cfg_cop == 3'd0 && !cfg_err);
  // R4
  cce_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cop == 3'd3 |-> cfg_cce == 2'd2);
  // R4
  cce_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cop == 3'd4 |-> cfg_cce == 2'd3);
  // R8
  err_no_new_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !$rose(out_valid));
endmodule

// File: tb/coll_reduce_dp_bench.sv
module coll_reduce_dp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_ctype = 8'd1, cfg_aluop = 8'h04, cfg_dtype = 8'h9;
  logic cfg_err;
  logic [2:0] cfg_cop;
  logic [1:0] cfg_cce;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coll_reduce_dp u_coll_reduce_dp (
    .clk(clk), .rst_n(rst_n), .cfg_ctype(cfg_ctype), .cfg_aluop(cfg_aluop),
    .cfg_dtype(cfg_dtype), .cfg_err(cfg_err), .cfg_cop(cfg_cop), .cfg_cce(cfg_cce),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected compute code from the opcode table
  function automatic int ref_cop(logic [7:0] op);
    if (op == 8'h04 || op == 8'hC4) return 1;
    if (op == 8'h08 || op == 8'hCF || op == 8'hD5) return 3;
    if (op == 8'h09 || op == 8'hD0 || op == 8'hD6) return 4;
    return -1;
  endfunction

  function automatic int ref_width(logic [7:0] dt);
    if (dt == 8'h2 || dt == 8'h3) return 8;
    if (dt == 8'h4 || dt == 8'h5) return 16;
    if (dt == 8'h8 || dt == 8'h9) return 32;
    return 0;
  endfunction

  function automatic bit ref_signed(logic [7:0] op, logic [7:0] dt);
    if (op == 8'hCF || op == 8'hD0) return 1'b1;
    if (op == 8'hD5 || op == 8'hD6) return 1'b0;
    return (dt == 8'h2 || dt == 8'h4 || dt == 8'h8);
  endfunction

  function automatic bit is_reduce(logic [7:0] ct);
    return ct == 8'd1 || ct == 8'd2 || ct == 8'd6 || ct == 8'd8;
  endfunction

  function automatic logic [31:0] ref_word(logic [7:0] ct, logic [7:0] op, logic [7:0] dt,
                                           logic [31:0] a, logic [31:0] b);
    int cop, w;
    bit sg;
    logic [31:0] res;
    longint m, x, y, r;
    if (!is_reduce(ct)) return a;
    cop = ref_cop(op);
    w   = ref_width(dt);
    sg  = ref_signed(op, dt);
    m   = (longint'(1) <<< w) - 1;
    res = '0;
    for (int i = 0; i < 32 / w; i++) begin
      x = (longint'(a) >>> (i * w)) & m;
      y = (longint'(b) >>> (i * w)) & m;
      if (sg && x > (m >>> 1)) x = x - (m + 1);
      if (sg && y > (m >>> 1)) y = y - (m + 1);
      case (cop)
        1: r = y + x;
        3: r = (y > x) ? y : x;
        4: r = (y < x) ? y : x;
        default: r = x;
      endcase
      res = res | 32'((r & m) <<< (i * w));
    end
    return res;
  endfunction

  task automatic set_cfg(input logic [7:0] ct, input logic [7:0] op, input logic [7:0] dt);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    cfg_ctype = ct;
    cfg_aluop = op;
    cfg_dtype = dt;
    #1;
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp, input string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_a      = a;
    in_b      = b;
    out_ready = 1'b1;
    #1;
    chk(in_ready, req, "in_ready before send", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && out_data == exp, req, "result word", out_data, exp);
  endtask

  task automatic check_cfg(input logic [7:0] op, input int exp_cop, input int exp_cce,
                           input string req);
    set_cfg(8'd2, op, 8'h9);
    chk(cfg_cop == 3'(exp_cop) && !cfg_err, req, "compute code", 32'(cfg_cop), 32'(exp_cop));
    chk(cfg_cce == 2'(exp_cce), "R4", "side code", 32'(cfg_cce), 32'(exp_cce));
  endtask

  task automatic check_blocked(input string req);
    chk(cfg_err == 1'b1, req, "cfg_err", 32'(cfg_err), 32'd1);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = 32'h1111_2222;
    in_b = 32'h3333_4444;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!in_ready && !out_valid, req, "blocked stream", {30'd0, in_ready, out_valid}, 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  logic [7:0] ops_l [8]  = '{8'h04, 8'hC4, 8'h08, 8'hCF, 8'hD5, 8'h09, 8'hD0, 8'hD6};
  logic [7:0] dts_l [6]  = '{8'h2, 8'h3, 8'h4, 8'h5, 8'h8, 8'h9};
  logic [7:0] kinds_l [9] = '{8'd1, 8'd2, 8'd6, 8'd8, 8'd3, 8'd4, 8'd5, 8'd7, 8'd9};

  task automatic random_segment(input int cycles);
    logic [31:0] q [$];
    logic [31:0] held;
    bit stall;
    stall = 1'b0;
    held  = '0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid  = ($urandom % 4) != 0;
      in_a      = $urandom;
      in_b      = $urandom;
      out_ready = ($urandom % 3) != 0;
      #1;
      if (stall)
        chk(out_valid && out_data == held, "R9", "hold under stall", out_data, held);
      stall = out_valid && !out_ready;
      held  = out_data;
      if (out_valid && out_ready) begin
        if (q.size() == 0)
          chk(1'b0, "R9", "unexpected output", out_data, 32'd0);
        else begin
          chk(out_data == q[0], "R5/R6/R7 stream (R9)", "stream word", out_data, q[0]);
          void'(q.pop_front());
        end
      end
      if (in_valid && in_ready)
        q.push_back(ref_word(cfg_ctype, cfg_aluop, cfg_dtype, in_a, in_b));
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1;
      if (out_valid) begin
        if (q.size() == 0)
          chk(1'b0, "R9", "extra output", out_data, 32'd0);
        else begin
          chk(out_data == q[0], "R9", "drained word", out_data, q[0]);
          void'(q.pop_front());
        end
      end
      @(negedge clk);
    end
    chk(q.size() == 0, "R9", "words lost", 32'(q.size()), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(!out_valid, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready, "R10", "in_ready after reset", 32'(in_ready), 32'd1);

    // R3 opcode mapping and R4 side code
    check_cfg(8'h04, 1, 0, "R3");
    check_cfg(8'hC4, 1, 0, "R3");
    check_cfg(8'h08, 3, 2, "R3");
    check_cfg(8'hCF, 3, 2, "R3");
    check_cfg(8'hD5, 3, 2, "R3");
    check_cfg(8'h09, 4, 3, "R3");
    check_cfg(8'hD0, 4, 3, "R3");
    check_cfg(8'hD6, 4, 3, "R3");

    // R6 byte wrap, no carry across lanes
    set_cfg(8'd1, 8'h04, 8'h3);
    run_one(32'h01_01_01_01, 32'hFF_7F_00_FE, 32'h00_80_01_FF, "R6");
    set_cfg(8'd8, 8'hC4, 8'h5);
    run_one(32'h0001_0002, 32'hFFFF_FFFF, 32'h0000_0001, "R6");
    set_cfg(8'd6, 8'h04, 8'h8);
    run_one(32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, "R6");

    // R7 signedness
    set_cfg(8'd1, 8'h08, 8'h2);
    run_one(32'h80_80_80_80, 32'h7F_7F_7F_7F, 32'h7F_7F_7F_7F, "R7");
    set_cfg(8'd1, 8'h08, 8'h3);
    run_one(32'h80_80_80_80, 32'h7F_7F_7F_7F, 32'h80_80_80_80, "R7");
    set_cfg(8'd1, 8'hCF, 8'h3);
    run_one(32'h80_00_80_00, 32'h7F_01_7F_01, 32'h7F_01_7F_01, "R7");
    set_cfg(8'd1, 8'hD6, 8'h4);
    run_one(32'h8000_0005, 32'h7FFF_0003, 32'h7FFF_0003, "R7");
    set_cfg(8'd2, 8'hD0, 8'h9);
    run_one(32'h8000_0000, 32'h0000_0001, 32'h8000_0000, "R7");

    // R5 lane packing: lane i of a 16-bit min is independent
    set_cfg(8'd2, 8'h09, 8'h5);
    run_one(32'h0010_FFF0, 32'h0020_0001, 32'h0010_0001, "R5");

    // R2 copy kinds ignore opcode and dtype
    set_cfg(8'd4, 8'h55, 8'h00);
    chk(cfg_cop == 3'd0 && !cfg_err, "R2", "copy config", {28'd0, cfg_err, cfg_cop}, 32'd0);
    run_one(32'hDEAD_BEEF, 32'h1234_5678, 32'hDEAD_BEEF, "R2");
    set_cfg(8'd9, 8'h04, 8'h2);
    chk(cfg_cce == 2'd0, "R4", "side code on copy", 32'(cfg_cce), 32'd0);
    run_one(32'h0101_0101, 32'hFFFF_FFFF, 32'h0101_0101, "R2");

    // R1 invalid kinds
    set_cfg(8'd0, 8'h04, 8'h9);
    check_blocked("R1");
    set_cfg(8'd10, 8'h04, 8'h9);
    check_blocked("R1");

    // R8 bad opcode or dtype on a reducing kind, then recovery
    set_cfg(8'd1, 8'h55, 8'h9);
    check_blocked("R8");
    set_cfg(8'd1, 8'h04, 8'h0A);
    check_blocked("R8");
    set_cfg(8'd1, 8'h04, 8'h9);
    chk(!cfg_err && in_ready, "R8", "recovered after config change", 32'(cfg_err), 32'd0);
    run_one(32'd5, 32'd7, 32'd12, "R8");

    // R9 throughput: a word every cycle with out_ready high
    set_cfg(8'd1, 8'h04, 8'h9);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_a = 32'(k);
      in_b = 32'd100;
      #1;
      chk(in_ready, "R9", "back-to-back accept", 32'(in_ready), 32'd1);
      if (k > 0)
        chk(out_valid && out_data == 32'(99 + k), "R9", "back-to-back word",
            out_data, 32'(99 + k));
    end
    @(negedge clk);
    in_valid = 1'b0;

    // random streams over legal configurations (R5 R6 R7 R9)
    for (int s = 0; s < 24; s++) begin
      set_cfg(kinds_l[$urandom % 9], ops_l[$urandom % 8], dts_l[$urandom % 6]);
      random_segment(300);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule